// File: doc/BRIEF.md
# Memory Device Identity Probe Sequencer

This block is the identity stage of a device programmer. When it is started, it puts the attached memory device into its self-identification state and reads three identity bytes. It then decides whether the part is the one the programmer expects. The block does not switch the high voltage itself. It raises a request line that tells the external supply to put the elevated voltage on address line 9. While that request is up, it drives every other address bit low except the two lowest, which pick the byte to read.

For each of the three bytes, the block does the following:
- It places the slot number on the two low address bits and pulls chip enable low.
- It then pulls output enable low and waits a parameterized number of access cycles.
- It captures the byte on the data bus while both enables are still low.

After the third byte it drops the voltage request and posts a result. The result says one of three things: the three bytes all match the expected codes, at least one byte fails odd parity (the index of the first failing byte is reported), or the bytes have correct parity but do not match. The expected codes are parameters, so the same sequencer can recognise other parts. The programmer uses the result to choose its programming algorithm.

Top module: `eprom_id_probe`

## Requirements
- R1: A start pulse accepted in the idle state raises hvReq on the next clock. hvReq stays high until the third byte has been captured and is low again one cycle before done rises. done is never high while hvReq, a low chip enable or a low output enable is present.
- R2: Whenever output enable falls, addrOut has all bits above bit 1 at zero. Its two low bits equal 0, 1 and 2 (binary 00, 01, 10) for the first, second and third byte, in that order.
- R3: After hvReq rises, ceN stays high for SETTLE_CYC cycles. It then falls one cycle before oeN. oeN is never low while ceN is high. oeN stays low for ACCESS_CYC full cycles before the capture cycle.
- R4: Each identity byte is taken from idData in the cycle after the access wait, while ceN and oeN are both low. It is shown on idByte0, idByte1 and idByte2 for slots 0, 1 and 2.
- R5: A captured byte with an even number of ones sets parityErr. errIndex gives the lowest slot whose byte fails odd parity, and is 0 when parityErr is low.
- R6: match is 1 only when no byte fails parity and the bytes equal MFR_CODE, DEV_CODE and CONT_CODE for slots 0, 1 and 2. These parameters default to 8'h37, 8'h64 and 8'h7F.
- R7: done rises SETTLE_CYC + 3*(ACCESS_CYC+2) + 1 clock edges after the edge that accepted start.
- R8: A start pulse while the sequence is running has no effect. The run keeps its timing, addresses and results.
- R9: done, match, parityErr, errIndex and the captured bytes hold their values until the next accepted start. An accepted start clears done on the next clock.
- R10: After reset, done, match and parityErr are 0, hvReq is 0, ceN and oeN are 1, addrOut is 0 and the captured bytes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an identity read (taken only when idle) |
| idData | input | 8 | Data bus from the attached device |
| hvReq | output | 1 | Request for the elevated voltage on address line 9 |
| addrOut | output | ADDR_W | Device address; only bits 1:0 are ever non-zero |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| done | output | 1 | Result valid |
| match | output | 1 | All three bytes equal the expected codes with good parity |
| parityErr | output | 1 | At least one byte failed odd parity |
| errIndex | output | 2 | Lowest slot with a parity failure |
| idByte0 | output | 8 | Captured manufacturer byte |
| idByte1 | output | 8 | Captured device byte |
| idByte2 | output | 8 | Captured continuation byte |

## Verification
The bench builds the probe with an 18-bit address, SETTLE_CYC = 3 and ACCESS_CYC = 4, and keeps the default expected codes. The settle and access values differ from each other, so an error in either wait shows up as a wrong run length. The device model outputs the even-parity filler 8'hEE until output enable has been low for ACCESS_CYC edges. A capture one cycle too early therefore turns into a parity error and a mismatch. Because the waits are short, a run lasts 22 cycles. This leaves room for matching codes, mismatching codes, several parity failure positions, busy-time start pulses and restarts.

// File: rtl/romid_pkg.sv
package romid_pkg;

  localparam int NUM_ID_BYTES = 3;
  localparam int SLOT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SELECT,
    ST_WAIT,
    ST_CAPTURE,
    ST_DROP
  } probeState_t;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic              clearRes;
    logic              capture;
    logic              finish;
    logic [SLOT_W-1:0] slot;
  } probeStrobe_t;

endpackage

// File: rtl/romid_ctrl.sv
module romid_ctrl
  import romid_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int ACCESS_CYC = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output probeStrobe_t strb,
  output logic         hvReq,
  output logic         ceN,
  output logic         oeN
);

  localparam int CNT_MAX = (SETTLE_CYC > ACCESS_CYC) ? SETTLE_CYC : ACCESS_CYC;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_LOAD = CNT_W'(ACCESS_CYC - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_ID_BYTES - 1);

  probeState_t       state;
  logic [CNT_W-1:0]  waitCnt;
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      slot    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SETTLE;
            waitCnt <= SETTLE_LOAD;
            slot    <= '0;
          end
        end
        ST_SETTLE: begin
          if (waitCnt == '0) state <= ST_SELECT;
          else waitCnt <= waitCnt - 1'b1;
        end
        ST_SELECT: begin
          state   <= ST_WAIT;
          waitCnt <= ACCESS_LOAD;
        end
        ST_WAIT: begin
          if (waitCnt == '0) state <= ST_CAPTURE;
          else waitCnt <= waitCnt - 1'b1;
        end
        ST_CAPTURE: begin
          if (slot == LAST_SLOT) begin
            state <= ST_DROP;
          end else begin
            slot  <= slot + 1'b1;
            state <= ST_SELECT;
          end
        end
        ST_DROP:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hvReq         = state inside {ST_SETTLE, ST_SELECT, ST_WAIT, ST_CAPTURE};
    ceN           = !(state inside {ST_SELECT, ST_WAIT, ST_CAPTURE});
    oeN           = !(state inside {ST_WAIT, ST_CAPTURE});
    strb.clearRes = (state == ST_IDLE) && start;
    strb.capture  = (state == ST_CAPTURE);
    strb.finish   = (state == ST_DROP);
    strb.slot     = (state inside {ST_SELECT, ST_WAIT, ST_CAPTURE}) ? slot : '0;
  end

endmodule

// File: rtl/romid_datapath.sv
module romid_datapath
  import romid_pkg::*;
#(
  parameter int         ADDR_W    = 18,
  parameter logic [7:0] MFR_CODE  = 8'h37,
  parameter logic [7:0] DEV_CODE  = 8'h64,
  parameter logic [7:0] CONT_CODE = 8'h7F
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  probeStrobe_t                     strb,
  input  logic [7:0]                       idData,
  output logic [ADDR_W-1:0]                addrOut,
  output logic [NUM_ID_BYTES-1:0][7:0]     capByte,
  output logic                             done,
  output logic                             match,
  output logic                             parityErr,
  output logic [SLOT_W-1:0]                errIndex
);

  localparam logic [NUM_ID_BYTES-1:0][7:0] EXP_CODE = {CONT_CODE, DEV_CODE, MFR_CODE};

  logic [NUM_ID_BYTES-1:0] oddOk;
  logic [NUM_ID_BYTES-1:0] eqOk;
  logic [SLOT_W-1:0]       firstBad;

  assign addrOut = ADDR_W'(strb.slot);

  for (genvar g = 0; g < NUM_ID_BYTES; g++) begin : gByte
    always_ff @(posedge clk) begin
      if (!rstN) capByte[g] <= '0;
      else if (strb.capture && (strb.slot == SLOT_W'(g))) capByte[g] <= idData;
    end
    assign oddOk[g] = ^capByte[g];
    assign eqOk[g]  = (capByte[g] == EXP_CODE[g]);
  end

  always_comb begin
    firstBad = '0;
    for (int i = NUM_ID_BYTES - 1; i >= 0; i--) begin
      if (!oddOk[i]) firstBad = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      match     <= 1'b0;
      parityErr <= 1'b0;
      errIndex  <= '0;
    end else if (strb.clearRes) begin
      done      <= 1'b0;
      match     <= 1'b0;
      parityErr <= 1'b0;
      errIndex  <= '0;
    end else if (strb.finish) begin
      done      <= 1'b1;
      match     <= (&oddOk) && (&eqOk);
      parityErr <= ~(&oddOk);
      errIndex  <= firstBad;
    end
  end

endmodule

// File: rtl/eprom_id_probe.sv
module eprom_id_probe
  import romid_pkg::*;
#(
  parameter int         ADDR_W     = 18,
  parameter int         SETTLE_CYC = 4,
  parameter int         ACCESS_CYC = 3,
  parameter logic [7:0] MFR_CODE   = 8'h37,
  parameter logic [7:0] DEV_CODE   = 8'h64,
  parameter logic [7:0] CONT_CODE  = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        idData,
  output logic              hvReq,
  output logic [ADDR_W-1:0] addrOut,
  output logic              ceN,
  output logic              oeN,
  output logic              done,
  output logic              match,
  output logic              parityErr,
  output logic [1:0]        errIndex,
  output logic [7:0]        idByte0,
  output logic [7:0]        idByte1,
  output logic [7:0]        idByte2
);

  probeStrobe_t                 strb;
  logic [NUM_ID_BYTES-1:0][7:0] capByte;

  romid_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .ACCESS_CYC(ACCESS_CYC)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .hvReq(hvReq),
    .ceN  (ceN),
    .oeN  (oeN)
  );

  romid_datapath #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE),
    .CONT_CODE(CONT_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .idData   (idData),
    .addrOut  (addrOut),
    .capByte  (capByte),
    .done     (done),
    .match    (match),
    .parityErr(parityErr),
    .errIndex (errIndex)
  );

  assign idByte0 = capByte[0];
  assign idByte1 = capByte[1];
  assign idByte2 = capByte[2];

endmodule

// File: rtl/eprom_id_probe_chk.sv
module eprom_id_probe_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              hvReq,
  input logic [ADDR_W-1:0] addrOut,
  input logic              ceN,
  input logic              oeN,
  input logic              done,
  input logic              match,
  input logic              parityErr,
  input logic [7:0]        idByte0,
  input logic [7:0]        idByte1,
  input logic [7:0]        idByte2
);

  assert_oe_inside_ce_R3: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !ceN);

  assert_settle_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hvReq) |-> ceN);

  assert_enable_needs_hv_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ceN |-> hvReq);

  assert_done_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!hvReq && ceN && oeN));

  assert_addr_upper_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (addrOut[ADDR_W-1:2] == '0 && addrOut[1:0] != 2'b11));

  assert_byte0_sampled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idByte0) |-> $past(!ceN && !oeN));

  assert_byte1_sampled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idByte1) |-> $past(!ceN && !oeN));

  assert_byte2_sampled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(idByte2) |-> $past(!ceN && !oeN));

  assert_match_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    match |-> !parityErr);

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hvReq && !ceN) |=> !done);

endmodule

bind eprom_id_probe eprom_id_probe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .hvReq    (hvReq),
  .addrOut  (addrOut),
  .ceN      (ceN),
  .oeN      (oeN),
  .done     (done),
  .match    (match),
  .parityErr(parityErr),
  .idByte0  (idByte0),
  .idByte1  (idByte1),
  .idByte2  (idByte2)
);

// File: tb/eprom_id_probe_tb.sv
module eprom_id_probe_tb;

  localparam int ADDR_W     = 18;
  localparam int SETTLE_CYC = 3;
  localparam int ACCESS_CYC = 4;
  localparam int RUN_LEN    = SETTLE_CYC + 3 * (ACCESS_CYC + 2) + 1;

  typedef struct packed {
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic        mt;
    logic        pe;
    logic [1:0]  ei;
    logic [31:0] startCyc;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        idData;
  logic              hvReq, ceN, oeN, done, match, parityErr;
  logic [ADDR_W-1:0] addrOut;
  logic [1:0]        errIndex;
  logic [7:0]        idByte0, idByte1, idByte2;

  int        checks = 0;
  int        fails = 0;
  int        cyc = 0;
  int        lowCnt = 0;
  int        orderIdx = 0;
  bit        finished = 0;
  logic [7:0] devCode [3];
  expItem_t  scoreQ [$];

  always #2.5 clk = ~clk;

  eprom_id_probe #(
    .ADDR_W    (ADDR_W),
    .SETTLE_CYC(SETTLE_CYC),
    .ACCESS_CYC(ACCESS_CYC)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .idData   (idData),
    .hvReq    (hvReq),
    .addrOut  (addrOut),
    .ceN      (ceN),
    .oeN      (oeN),
    .done     (done),
    .match    (match),
    .parityErr(parityErr),
    .errIndex (errIndex),
    .idByte0  (idByte0),
    .idByte1  (idByte1),
    .idByte2  (idByte2)
  );

  // device model: valid identity byte only after ACCESS_CYC edges of low output enable
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (oeN) lowCnt <= 0;
    else lowCnt <= lowCnt + 1;
  end

  always_comb begin
    if (hvReq && !ceN && !oeN && addrOut[ADDR_W-1:2] == '0 &&
        addrOut[1:0] != 2'b11 && lowCnt >= ACCESS_CYC)
      idData = devCode[addrOut[1:0]];
    else
      idData = 8'hEE;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: address order at each output-enable fall, results at done rise
  initial begin
    logic prevOe = 1'b1;
    logic prevDone = 1'b0;
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN && !oeN && prevOe) begin
        check(addrOut[ADDR_W-1:2] == '0, "R2 upper address bits", 32'(addrOut), 0);
        check(addrOut[1:0] == 2'(orderIdx), "R2 slot order", 32'(addrOut[1:0]),
              32'(orderIdx));
        orderIdx++;
      end
      if (rstN && done && !prevDone) begin
        if (scoreQ.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          it = scoreQ.pop_front();
          check(32'(cyc) - it.startCyc == RUN_LEN, "R7 run length",
                32'(cyc) - it.startCyc, RUN_LEN);
          check(idByte0 == it.b0, "R4 byte0", idByte0, it.b0);
          check(idByte1 == it.b1, "R4 byte1", idByte1, it.b1);
          check(idByte2 == it.b2, "R4 byte2", idByte2, it.b2);
          check(parityErr == it.pe, "R5 parity flag", parityErr, it.pe);
          check(errIndex == it.ei, "R5 error index", errIndex, it.ei);
          check(match == it.mt, "R6 match", match, it.mt);
          check(orderIdx == 3, "R2 three reads", orderIdx, 3);
          check(!hvReq, "R1 hv dropped", hvReq, 0);
        end
      end
      prevOe = oeN;
      prevDone = done;
    end
  end

  task automatic runProbe(input logic [7:0] c0, input logic [7:0] c1,
                          input logic [7:0] c2, input bit poke);
    expItem_t it;
    logic [2:0] odd;
    bit wasDone;
    devCode[0] = c0;
    devCode[1] = c1;
    devCode[2] = c2;
    odd = {^c2, ^c1, ^c0};
    it.b0 = c0;
    it.b1 = c1;
    it.b2 = c2;
    it.pe = ~&odd;
    it.ei = !odd[0] ? 2'd0 : (!odd[1] ? 2'd1 : (!odd[2] ? 2'd2 : 2'd0));
    it.mt = (&odd) && c0 == 8'h37 && c1 == 8'h64 && c2 == 8'h7F;
    @(negedge clk);
    wasDone = done;
    orderIdx = 0;
    it.startCyc = 32'(cyc + 1);
    scoreQ.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(hvReq, "R1 hv request raised", hvReq, 1);
    if (wasDone) check(!done, "R9 restart clears done", done, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (scoreQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !match && !parityErr, "R10 reset results", {done, match, parityErr}, 0);
    check(!hvReq && ceN && oeN, "R10 reset controls", {hvReq, ceN, oeN}, 3'b011);
    check(addrOut == '0 && idByte0 == 0, "R10 reset address and bytes", 32'(addrOut), 0);

    runProbe(8'h37, 8'h64, 8'h7F, 0);   // R6 matching part
    repeat (10) @(negedge clk);
    check(done && match && idByte1 == 8'h64, "R9 results hold", {done, match}, 2'b11);
    runProbe(8'h1C, 8'h64, 8'h7F, 0);   // R6 odd parity, wrong maker
    runProbe(8'h37, 8'h65, 8'h7F, 0);   // R5 parity failure in slot 1
    runProbe(8'h36, 8'h64, 8'h7E, 0);   // R5 failures in slots 0 and 2
    runProbe(8'h37, 8'h64, 8'h7E, 0);   // R5 failure in slot 2
    runProbe(8'h37, 8'h64, 8'h7F, 1);   // R8 start pulses while busy
    runProbe(8'h80, 8'h01, 8'hFE, 1);   // R8 and R6 odd bytes, no match
    runProbe(8'h00, 8'h00, 8'h00, 0);   // R5 all even
    runProbe(8'h37, 8'h64, 8'h7F, 0);   // R3 access wait covered after errors
    repeat (4) @(negedge clk);
    check(done && !hvReq, "R9 final results held", {done, hvReq}, 2'b10);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule